// File: doc/BRIEF.md
# Reconfigurable Post-Processing ALU

This block is a short arithmetic pipeline that applies non-convolution operators to the values a convolution array produces. One chain of hardware serves many operators: a threshold comparator, a pre-multiplier, a middle adder with an accumulator, and a back multiplier, followed by an arithmetic right shift and saturation. Per-beat function selects and operand ports choose the operator. Max pooling, average pooling, batch-norm scale and shift, depthwise scaling, ReLU, ReLU6, element-wise add and rescaling are all settings of the same chain.

Every operator works on windows of beats. A window-start strobe clears the running maximum or the running sum. A window-end strobe produces one registered result. A pointwise operator is a window of length one, with both strobes set on the same beat. Each window stays within one channel group. The block never combines data across channels.

The input sample, the strobes and the configuration are registered together. The output is registered too. A result therefore appears two clock edges after the beat that closes its window. Micro-command fetch, address generation and storage belong to the surrounding logic.

Top module: `pp_alu`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and out_data_o is 0.
- R2: A beat with in_valid_i=1 and win_end_i=1 sets out_valid_o high after exactly two rising edges. A cycle whose beat does not close a window gives out_valid_o=0 two edges later, and out_data_o keeps its last value.
- R3: The compare stage uses cmp_fn_i to produce c. Code 0 gives c=x. Code 1 gives c=max(x, thr_i). Code 2 gives c=min(max(x, 0), thr_i). All values are signed 16-bit.
- R4: With cmp_fn_i=3, c is x on a beat where win_start_i=1. On other beats c is max(x, running maximum). Each valid beat with code 3 updates the running maximum to c.
- R5: The pre-multiplier forms the full signed product p = c * pre_op_i.
- R6: add_fn_i selects the middle value m. Code 0 (and the unused code 3) gives m=p. Code 1 gives m = p + shared_i, with shared_i sign-extended.
- R7: add_fn_i=2 gives m = p + acc, where acc counts as 0 on a beat with win_start_i=1. Each valid beat with code 2 updates acc to m. The accumulator is 40 bits wide by default.
- R8: The result before saturation is (m * back_op_i) shifted arithmetically right by shift_i, which ranges from 0 to 31.
- R9: The result saturates to the signed 16-bit range, -32768 to 32767.
- R10: A cycle with in_valid_i=0 ignores the sample, the strobes and the configuration on the inputs. It changes neither the running maximum nor the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Beat valid |
| win_start_i | input | 1 | First beat of a window |
| win_end_i | input | 1 | Last beat of a window |
| data_i | input | 16 | Signed input sample |
| cmp_fn_i | input | 2 | Compare-function select |
| add_fn_i | input | 2 | Add-function select |
| thr_i | input | 16 | Signed threshold |
| pre_op_i | input | 16 | Signed pre-multiplier operand |
| shared_i | input | 16 | Signed shared adder operand (bias or second addend) |
| back_op_i | input | 16 | Signed back-multiplier operand |
| shift_i | input | 5 | Right-shift amount |
| out_valid_o | output | 1 | Result valid |
| out_data_o | output | 16 | Saturated signed result |

## Verification
A beat is captured at the first rising edge after it is driven. Its result is registered at the second rising edge. The bench drives each beat at a falling edge and, at every falling edge, compares the outputs with the expectation computed two calls earlier. It holds these expectations in a two-slot pipeline.

Every cycle is checked. The bench checks data only on cycles where it expects a result. On every other cycle it checks that out_valid_o is low and that out_data_o has held its value. As a result, idle cycles mixed into windows show at the ports whether they disturbed the running maximum or the sum.

// File: rtl/pp_alu_pkg.sv
package pp_alu_pkg;
  typedef enum logic [1:0] {
    CMP_PASS   = 2'd0,
    CMP_FLOOR  = 2'd1,
    CMP_CLAMP  = 2'd2,
    CMP_RUNMAX = 2'd3
  } cmp_fn_e;

  typedef enum logic [1:0] {
    ADD_BYPASS = 2'd0,
    ADD_SHARED = 2'd1,
    ADD_ACCUM  = 2'd2,
    ADD_RSVD   = 2'd3
  } add_fn_e;
endpackage

// File: rtl/pp_alu_cmp.sv
module pp_alu_cmp
  import pp_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 beat_i,
  input  logic                 start_i,
  input  cmp_fn_e              fn_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] thr_i,
  output logic signed [DW-1:0] c_o
);
  logic signed [DW-1:0] run_max_q;
  logic signed [DW-1:0] floor_v, relu_v, clamp_v, runmax_v, ref_v;

  always_comb begin
    floor_v  = (x_i > thr_i) ? x_i : thr_i;
    relu_v   = x_i[DW-1] ? '0 : x_i;
    clamp_v  = (relu_v > thr_i) ? thr_i : relu_v;
    ref_v    = run_max_q;
    runmax_v = (start_i || (x_i > ref_v)) ? x_i : ref_v;
    unique case (fn_i)
      CMP_PASS:   c_o = x_i;
      CMP_FLOOR:  c_o = floor_v;
      CMP_CLAMP:  c_o = clamp_v;
      default:    c_o = runmax_v;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            run_max_q <= '0;
    else if (beat_i && fn_i == CMP_RUNMAX)  run_max_q <= runmax_v;
  end
endmodule

// File: rtl/pp_alu_mid.sv
module pp_alu_mid
  import pp_alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 beat_i,
  input  logic                 start_i,
  input  add_fn_e              fn_i,
  input  logic signed [DW-1:0] c_i,
  input  logic signed [DW-1:0] pre_op_i,
  input  logic signed [DW-1:0] shared_i,
  output logic signed [AW-1:0] m_o
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] c_ext, op_ext, prod;
  logic signed [AW-1:0] p_ext, sh_ext, acc_q, acc_base, sum_v;

  always_comb begin
    c_ext    = PW'(c_i);
    op_ext   = PW'(pre_op_i);
    prod     = c_ext * op_ext;
    p_ext    = AW'(prod);
    sh_ext   = AW'(shared_i);
    acc_base = start_i ? '0 : acc_q;
    sum_v    = acc_base + p_ext;
    unique case (fn_i)
      ADD_SHARED: m_o = p_ext + sh_ext;
      ADD_ACCUM:  m_o = sum_v;
      default:    m_o = p_ext;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          acc_q <= '0;
    else if (beat_i && fn_i == ADD_ACCUM) acc_q <= sum_v;
  end
endmodule

// File: rtl/pp_alu_back.sv
module pp_alu_back #(
  parameter int DW  = 16,
  parameter int AW  = 40,
  parameter int SHW = 5
) (
  input  logic signed [AW-1:0]  m_i,
  input  logic signed [DW-1:0]  back_op_i,
  input  logic        [SHW-1:0] shift_i,
  output logic signed [DW-1:0]  res_o
);
  localparam int BW = AW + DW;
  localparam logic signed [BW-1:0] MAXV = BW'({1'b0, {(DW-1){1'b1}}});
  localparam logic signed [BW-1:0] MINV = -MAXV - BW'(1);

  logic signed [BW-1:0] m_ext, b_ext, prod, shifted;

  always_comb begin
    m_ext   = BW'(m_i);
    b_ext   = BW'(back_op_i);
    prod    = m_ext * b_ext;
    shifted = prod >>> shift_i;
    if (shifted > MAXV)      res_o = MAXV[DW-1:0];
    else if (shifted < MINV) res_o = MINV[DW-1:0];
    else                     res_o = shifted[DW-1:0];
  end
endmodule

// File: rtl/pp_alu.sv
module pp_alu
  import pp_alu_pkg::*;
#(
  parameter int DW        = 16,
  parameter int ACC_GUARD = 8,
  parameter int SHW       = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  input  logic           win_start_i,
  input  logic           win_end_i,
  input  logic [DW-1:0]  data_i,
  input  logic [1:0]     cmp_fn_i,
  input  logic [1:0]     add_fn_i,
  input  logic [DW-1:0]  thr_i,
  input  logic [DW-1:0]  pre_op_i,
  input  logic [DW-1:0]  shared_i,
  input  logic [DW-1:0]  back_op_i,
  input  logic [SHW-1:0] shift_i,
  output logic           out_valid_o,
  output logic [DW-1:0]  out_data_o
);
  localparam int AW = 2 * DW + ACC_GUARD;

  logic                  s_valid, s_start, s_end;
  cmp_fn_e               s_cmp;
  add_fn_e               s_add;
  logic signed [DW-1:0]  s_x, s_thr, s_pre, s_shr, s_back;
  logic        [SHW-1:0] s_shift;

  logic signed [DW-1:0]  c_v, res_v;
  logic signed [AW-1:0]  m_v;

  // input register: sample, strobes and configuration travel together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_valid <= 1'b0;
      s_start <= 1'b0;
      s_end   <= 1'b0;
      s_cmp   <= CMP_PASS;
      s_add   <= ADD_BYPASS;
      s_x     <= '0;
      s_thr   <= '0;
      s_pre   <= '0;
      s_shr   <= '0;
      s_back  <= '0;
      s_shift <= '0;
    end else begin
      s_valid <= in_valid_i;
      if (in_valid_i) begin
        s_start <= win_start_i;
        s_end   <= win_end_i;
        s_cmp   <= cmp_fn_e'(cmp_fn_i);
        s_add   <= add_fn_e'(add_fn_i);
        s_x     <= data_i;
        s_thr   <= thr_i;
        s_pre   <= pre_op_i;
        s_shr   <= shared_i;
        s_back  <= back_op_i;
        s_shift <= shift_i;
      end
    end
  end

  pp_alu_cmp #(.DW(DW)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .beat_i  (s_valid),
    .start_i (s_start),
    .fn_i    (s_cmp),
    .x_i     (s_x),
    .thr_i   (s_thr),
    .c_o     (c_v)
  );

  pp_alu_mid #(.DW(DW), .AW(AW)) u_mid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .beat_i   (s_valid),
    .start_i  (s_start),
    .fn_i     (s_add),
    .c_i      (c_v),
    .pre_op_i (s_pre),
    .shared_i (s_shr),
    .m_o      (m_v)
  );

  pp_alu_back #(.DW(DW), .AW(AW), .SHW(SHW)) u_back (
    .m_i       (m_v),
    .back_op_i (s_back),
    .shift_i   (s_shift),
    .res_o     (res_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= s_valid && s_end;
      if (s_valid && s_end) out_data_o <= res_v;
    end
  end
endmodule

// File: rtl/pp_alu_chk.sv
module pp_alu_chk #(
  parameter int DW  = 16,
  parameter int SHW = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_valid_i,
  input logic           win_end_i,
  input logic [DW-1:0]  data_i,
  input logic [1:0]     cmp_fn_i,
  input logic [1:0]     add_fn_i,
  input logic [DW-1:0]  thr_i,
  input logic [DW-1:0]  pre_op_i,
  input logic [DW-1:0]  back_op_i,
  input logic [SHW-1:0] shift_i,
  input logic           out_valid_o,
  input logic [DW-1:0]  out_data_o
);
  logic unity;
  assign unity = (pre_op_i == DW'(1)) && (add_fn_i == 2'd0) &&
                 (back_op_i == DW'(1)) && (shift_i == '0);

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && out_data_o == '0));

  p_end_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && win_end_i) |=> ##1 out_valid_o);

  p_no_end_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && win_end_i) |=> ##1 !out_valid_o);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));

  p_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && win_end_i && cmp_fn_i == 2'd1 && unity)
      |=> ##1 ($signed(out_data_o) >= $signed($past(thr_i, 2))));

  p_runmax_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && win_end_i && cmp_fn_i == 2'd3 && unity)
      |=> ##1 ($signed(out_data_o) >= $signed($past(data_i, 2))));
endmodule

bind pp_alu pp_alu_chk #(.DW(DW), .SHW(SHW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .win_end_i   (win_end_i),
  .data_i      (data_i),
  .cmp_fn_i    (cmp_fn_i),
  .add_fn_i    (add_fn_i),
  .thr_i       (thr_i),
  .pre_op_i    (pre_op_i),
  .back_op_i   (back_op_i),
  .shift_i     (shift_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/pp_alu_tb_top.sv
`timescale 1ns/1ps
module pp_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, win_start_i = 1'b0, win_end_i = 1'b0;
  logic [15:0] data_i = '0, thr_i = '0, pre_op_i = '0, shared_i = '0, back_op_i = '0;
  logic [1:0]  cmp_fn_i = '0, add_fn_i = '0;
  logic [4:0]  shift_i = '0;
  logic        out_valid_o;
  logic [15:0] out_data_o;

  int n_run = 0, n_fail = 0;
  longint rm_m = 0, acc_m = 0, held = 0;
  bit     e_v[2];
  longint e_d[2];
  string  e_tag[2];
  string  force_tag = "";

  always #2.5 clk_i = ~clk_i;

  pp_alu dut_i (.*);

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sx(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic model(bit v, bit st, bit en, logic [15:0] xr, int cmp, int add,
                       logic [15:0] thr_r, logic [15:0] pre_r, logic [15:0] shr_r,
                       logic [15:0] back_r, int sh);
    longint x, thr, c, p, m, r, rs;
    string tag;
    x = sx(xr); thr = sx(thr_r);
    case (cmp)
      0: c = x;
      1: c = (x > thr) ? x : thr;
      2: begin c = (x < 0) ? 0 : x; if (c > thr) c = thr; end
      default: c = (st || x > rm_m) ? x : rm_m;
    endcase
    if (v && cmp == 3) rm_m = c;
    p = c * sx(pre_r);
    case (add)
      1: m = p + sx(shr_r);
      2: begin m = (st ? 0 : acc_m) + p; if (v) acc_m = m; end
      default: m = p;
    endcase
    rs = (m * sx(back_r)) >>> sh;
    r = rs > 32767 ? 32767 : (rs < -32768 ? -32768 : rs);
    if (force_tag != "")                         tag = force_tag;
    else if (r != rs)                            tag = "R9";
    else if (add == 2)                           tag = "R7";
    else if (cmp == 3)                           tag = "R4";
    else if (add == 1)                           tag = "R6";
    else if (sh != 0 || sx(back_r) != 1)         tag = "R8";
    else if (sx(pre_r) != 1)                     tag = "R5";
    else                                         tag = "R3";
    e_v[0] = v && en; e_d[0] = r; e_tag[0] = tag;
  endtask

  task automatic beat(bit v, bit st, bit en, logic [15:0] x, int cmp, int add,
                      logic [15:0] thr, logic [15:0] pre, logic [15:0] shr,
                      logic [15:0] back, int sh);
    @(negedge clk_i);
    chk(e_v[1] ? e_tag[1] : "R2", longint'(out_valid_o), longint'(e_v[1]));
    if (e_v[1]) held = e_d[1];
    chk(e_v[1] ? e_tag[1] : "R2", sx(out_data_o), held);
    e_v[1] = e_v[0]; e_d[1] = e_d[0]; e_tag[1] = e_tag[0];
    in_valid_i = v; win_start_i = st; win_end_i = en; data_i = x;
    cmp_fn_i = 2'(cmp); add_fn_i = 2'(add); thr_i = thr; pre_op_i = pre;
    shared_i = shr; back_op_i = back; shift_i = 5'(sh);
    model(v, st, en, x, cmp, add, thr, pre, shr, back, sh);
  endtask

  task automatic idle_junk();
    beat(1'b0, 1'b1, 1'b1, 16'(($urandom)), 3, 2, 16'h7fff, 16'h7fff, 16'h7fff, 16'h7fff, 0);
  endtask

  task automatic point(logic [15:0] x, int cmp, int add, logic [15:0] thr,
                       logic [15:0] pre, logic [15:0] shr, logic [15:0] back, int sh);
    beat(1'b1, 1'b1, 1'b1, x, cmp, add, thr, pre, shr, back, sh);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int rnd;
    rnd = $urandom(32'h5eed_1234);
    e_v[0] = 0; e_v[1] = 0; e_d[0] = 0; e_d[1] = 0; e_tag[0] = "R2"; e_tag[1] = "R2";
    repeat (3) @(negedge clk_i);
    chk("R1", longint'(out_valid_o), 0);
    chk("R1", sx(out_data_o), 0);
    rst_ni = 1'b1;

    // R3 pointwise compare functions: ReLU, ReLU6 (6.0 in Q8), pass
    point(16'hff00, 1, 0, 16'h0000, 16'd1, 16'd0, 16'd1, 0);
    point(16'h0234, 1, 0, 16'h0000, 16'd1, 16'd0, 16'd1, 0);
    point(16'h0900, 2, 0, 16'h0600, 16'd1, 16'd0, 16'd1, 0);
    point(16'h8000, 2, 0, 16'h0600, 16'd1, 16'd0, 16'd1, 0);
    point(16'h0321, 2, 0, 16'h0600, 16'd1, 16'd0, 16'd1, 0);
    point(16'hfffb, 0, 0, 16'h0000, 16'd1, 16'd0, 16'd1, 0);
    // R5 pre-multiply, R6 batch-norm shift and element add, R8 rescale
    point(16'hfff0, 0, 0, 16'h0000, 16'd300, 16'd0, 16'd1, 0);
    point(16'h0100, 0, 1, 16'h0000, 16'h0180, 16'hf000, 16'd1, 8);
    point(16'h1234, 0, 1, 16'h0000, 16'd1, 16'h0111, 16'd1, 0);
    point(16'hfc00, 0, 0, 16'h0000, 16'd1, 16'd0, 16'd3, 2);
    // R9 saturation both ways
    point(16'h7fff, 0, 0, 16'h0000, 16'h7fff, 16'd0, 16'd1, 0);
    point(16'h8000, 0, 0, 16'h0000, 16'h7fff, 16'd0, 16'd1, 0);
    point(16'h7fff, 0, 1, 16'h0000, 16'd1, 16'h7fff, 16'd1, 31);
    // R4 max pool window of 4 with a start clearing a large old maximum
    beat(1, 1, 0, 16'hfff0, 3, 0, 0, 1, 0, 1, 0);
    beat(1, 0, 0, 16'hffe0, 3, 0, 0, 1, 0, 1, 0);
    beat(1, 0, 0, 16'hfff8, 3, 0, 0, 1, 0, 1, 0);
    beat(1, 0, 1, 16'hff00, 3, 0, 0, 1, 0, 1, 0);
    // R7 average pool of 4, reciprocal 0.25 in Q16
    beat(1, 1, 0, 16'd100, 0, 2, 0, 1, 0, 16'd16384, 16);
    beat(1, 0, 0, 16'd200, 0, 2, 0, 1, 0, 16'd16384, 16);
    beat(1, 0, 0, 16'd300, 0, 2, 0, 1, 0, 16'd16384, 16);
    beat(1, 0, 1, 16'd401, 0, 2, 0, 1, 0, 16'd16384, 16);
    // R10 invalid cycles with junk strobes inside windows
    force_tag = "R10";
    beat(1, 1, 0, 16'd50, 3, 2, 0, 1, 0, 1, 0);
    idle_junk();
    beat(1, 0, 0, 16'd20, 3, 2, 0, 1, 0, 1, 0);
    idle_junk();
    idle_junk();
    beat(1, 0, 1, 16'd10, 3, 2, 0, 1, 0, 1, 0);
    force_tag = "";
    repeat (2) beat(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // constrained random windows
    for (int w = 0; w < 400; w++) begin
      int cmp, add, len, sh;
      logic [15:0] thr, pre, shr, back;
      cmp = $urandom_range(0, 3);
      add = $urandom_range(0, 3);
      len = (add == 2 || cmp == 3) ? $urandom_range(1, 8) : 1;
      sh = $urandom_range(0, 20);
      thr = 16'($urandom); pre = 16'($urandom); shr = 16'($urandom);
      back = 16'($urandom);
      if ($urandom_range(0, 3) == 0) begin pre = 16'd1; back = 16'd1; sh = 0; end
      for (int k = 0; k < len; k++) begin
        if ($urandom_range(0, 3) == 0) idle_junk();
        beat(1, k == 0, k == len - 1, 16'($urandom), cmp, add, thr, pre, shr, back, sh);
      end
    end
    repeat (3) beat(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule